// File: doc/BRIEF.md
# Software-Side Register Field Controller

This block holds one register field of configurable width and applies the software-side access rules to it. A CPU request port carries a request, a write flag, per-field write data and a field-select strobe, and it returns read data. Two parameters choose how a write changes the stored bits and whether a read has a side effect. A third parameter can gate software writes with a hardware qualifier input of either polarity.

The field's stored value is always driven out. Two single-cycle strobes tell neighbouring hardware when the field is sampled by a read and when software changes it. The surrounding register block supplies the address decode, the bus bridge, the readback mux and any hardware-side update path.

Top module: `swfield_ctrl`

## Requirements
- R1: In plain write mode (write-mode code 0), an accepted write loads the write data into the field. The new value appears on `field_q` at the next clock edge.
- R2: In write-mode codes 1, 2 and 3, an accepted write sets, clears or inverts (in that order of codes) every stored bit whose write-data bit is 1. All other bits keep their value.
- R3: In write-mode codes 4, 5 and 6, an accepted write sets, clears or inverts (in that order of codes) every stored bit whose write-data bit is 0. For example, an 8-bit field holding 0x00 that is written 0xFE under code 4 becomes 0x01.
- R4: Write-mode code 7 makes any accepted write load all zeros. Code 8 makes it load all ones. The write data has no effect in either mode.
- R5: With read-clear (read-mode code 1) or read-set (code 2), a read returns the value held before the read. The field then holds all zeros or all ones from the next edge. With read-mode code 0, a read leaves the field unchanged.
- R6: With qualifier mode 1, a write is accepted only while `qual_in` is 1. With mode 2, a write is accepted only while `qual_in` is 0. With mode 0, every write is accepted. `qual_in` is sampled in the same cycle as the write, and a refused write leaves the field unchanged.
- R7: `acc_strobe` is high in exactly those cycles in which `req`, `sel` and a low `req_wr` mark a read of the field.
- R8: `mod_strobe` is high in exactly those cycles in which software changes the field: an accepted write, or a read in read-clear or read-set mode. When `mod_strobe` is low, `field_q` holds its value across the next edge.
- R9: `rd_data` equals `field_q` during a read and is zero in every other cycle.
- R10: A synchronous active-high reset loads the field with the parameter `RESET_VAL`.
- R11: Any cycle without both `req` and `sel` high leaves the field unchanged and keeps both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | CPU request valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| sel | input | 1 | Field-select strobe from the address decode |
| wr_data | input | WIDTH | Write data for this field |
| qual_in | input | 1 | Hardware write qualifier |
| rd_data | output | WIDTH | Read data, zero outside reads |
| field_q | output | WIDTH | Stored field value |
| acc_strobe | output | 1 | One-cycle read-sample strobe |
| mod_strobe | output | 1 | One-cycle software-modify strobe |

## Verification
All nine write modes are instantiated together and receive the same request stream, which includes the data values 0xFE, 0xFF, 0x00 and 0xA5. Complementary and all-one patterns separate the one-written modes from the zero-written ones, and they expose a data-independent forcing mode. Reads repeated on read-clear and read-set fields separate returning the old value from returning the new one. Writes with the qualifier at 1 and at 0, sent to fields that use opposite qualifier polarities, show whether the polarity is honoured. Cycles with `sel` or `req` low show that those cycles are ignored. A pseudo-random phase then mixes all of these patterns.

// File: rtl/swfield_pkg.sv
package swfield_pkg;

   typedef enum logic [3:0] {
      WM_PLAIN = 4'd0,
      WM_ONE_SET = 4'd1,
      WM_ONE_CLR = 4'd2,
      WM_ONE_TOG = 4'd3,
      WM_ZERO_SET = 4'd4,
      WM_ZERO_CLR = 4'd5,
      WM_ZERO_TOG = 4'd6,
      WM_FORCE_CLR = 4'd7,
      WM_FORCE_SET = 4'd8
   } wr_mode_e;

   typedef enum logic [1:0] {
      RM_NONE = 2'd0,
      RM_CLR = 2'd1,
      RM_SET = 2'd2
   } rd_mode_e;

   typedef enum logic [1:0] {
      QM_NONE = 2'd0,
      QM_HIGH = 2'd1,
      QM_LOW = 2'd2
   } qual_mode_e;

endpackage

// File: rtl/swfield_qual.sv
module swfield_qual
   import swfield_pkg::*;
#(
   parameter qual_mode_e QUAL_MODE = QM_NONE
) (
   input  logic qual_in,
   output logic qual_ok
);
   if (QUAL_MODE == QM_HIGH) begin : g_high
      assign qual_ok = qual_in;
   end else if (QUAL_MODE == QM_LOW) begin : g_low
      assign qual_ok = ~qual_in;
   end else begin : g_none
      assign qual_ok = qual_in | 1'b1;
   end
endmodule

// File: rtl/swfield_wr_next.sv
module swfield_wr_next
   import swfield_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter wr_mode_e WR_MODE = WM_PLAIN
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] data,
   output logic [WIDTH-1:0] nxt
);
   always_comb begin
      case (WR_MODE)
         WM_ONE_SET:   nxt = cur | data;
         WM_ONE_CLR:   nxt = cur & ~data;
         WM_ONE_TOG:   nxt = cur ^ data;
         WM_ZERO_SET:  nxt = cur | ~data;
         WM_ZERO_CLR:  nxt = cur & data;
         WM_ZERO_TOG:  nxt = cur ^ ~data;
         WM_FORCE_CLR: nxt = (cur & data) & '0;
         WM_FORCE_SET: nxt = (cur | data) | '1;
         default:      nxt = data;
      endcase
   end
endmodule

// File: rtl/swfield_rd_next.sv
module swfield_rd_next
   import swfield_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter rd_mode_e RD_MODE = RM_NONE
) (
   input  logic [WIDTH-1:0] cur,
   output logic             has_effect,
   output logic [WIDTH-1:0] nxt
);
   if (RD_MODE == RM_CLR) begin : g_clr
      assign has_effect = 1'b1;
      assign nxt = cur & '0;
   end else if (RD_MODE == RM_SET) begin : g_set
      assign has_effect = 1'b1;
      assign nxt = cur | '1;
   end else begin : g_none
      assign has_effect = 1'b0;
      assign nxt = cur;
   end
endmodule

// File: rtl/swfield_ctrl.sv
module swfield_ctrl
   import swfield_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter logic [WIDTH-1:0] RESET_VAL = '0,
   parameter wr_mode_e WR_MODE = WM_PLAIN,
   parameter rd_mode_e RD_MODE = RM_NONE,
   parameter qual_mode_e QUAL_MODE = QM_NONE
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req,
   input  logic             req_wr,
   input  logic             sel,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             qual_in,
   output logic [WIDTH-1:0] rd_data,
   output logic [WIDTH-1:0] field_q,
   output logic             acc_strobe,
   output logic             mod_strobe
);
   localparam logic [WIDTH-1:0] ZERO_V = '0;

   if (WIDTH < 1) begin : g_bad_width
      $error("swfield_ctrl: WIDTH must be at least 1");
   end

   logic             qual_ok;
   logic             rd_hit;
   logic             wr_hit;
   logic             rd_effect;
   logic [WIDTH-1:0] wr_nxt;
   logic [WIDTH-1:0] rd_nxt;
   logic [WIDTH-1:0] store_q;

   swfield_qual #(.QUAL_MODE(QUAL_MODE)) u_qual (
      .qual_in (qual_in),
      .qual_ok (qual_ok)
   );

   swfield_wr_next #(.WIDTH(WIDTH), .WR_MODE(WR_MODE)) u_wr (
      .cur  (store_q),
      .data (wr_data),
      .nxt  (wr_nxt)
   );

   swfield_rd_next #(.WIDTH(WIDTH), .RD_MODE(RD_MODE)) u_rd (
      .cur        (store_q),
      .has_effect (rd_effect),
      .nxt        (rd_nxt)
   );

   assign rd_hit = req & sel & ~req_wr;
   assign wr_hit = req & sel & req_wr & qual_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         store_q <= RESET_VAL;
      end else if (wr_hit) begin
         store_q <= wr_nxt;
      end else if (rd_hit && rd_effect) begin
         store_q <= rd_nxt;
      end
   end

   assign field_q    = store_q;
   assign rd_data    = rd_hit ? store_q : ZERO_V;
   assign acc_strobe = rd_hit;
   assign mod_strobe = wr_hit | (rd_hit & rd_effect);

   // R8: no modify strobe means the field holds
   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !mod_strobe |=> $stable(field_q));

   // R9: read data mirrors the stored value on a sampled read
   assert_rd_mirror_R9: assert property (@(posedge clk) disable iff (rst)
      acc_strobe |-> rd_data == field_q);

   // R11: idle cycles raise no strobe
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      !(req && sel) |-> !acc_strobe && !mod_strobe);

   if (WR_MODE == WM_PLAIN) begin : g_chk_plain
      assert_plain_load_R1: assert property (@(posedge clk) disable iff (rst)
         (req && sel && req_wr && qual_ok) |=> field_q == $past(wr_data));
   end
   if (WR_MODE == WM_ONE_SET) begin : g_chk_set
      assert_one_set_R2: assert property (@(posedge clk) disable iff (rst)
         (req && sel && req_wr && qual_ok) |=>
            (field_q & $past(wr_data)) == $past(wr_data));
   end
   if (RD_MODE == RM_CLR) begin : g_chk_rdclr
      assert_rd_clear_R5: assert property (@(posedge clk) disable iff (rst)
         acc_strobe |=> field_q == ZERO_V);
   end
   if (QUAL_MODE == QM_HIGH) begin : g_chk_qual
      assert_blocked_R6: assert property (@(posedge clk) disable iff (rst)
         (req && sel && req_wr && !qual_in) |=> $stable(field_q));
   end
endmodule

// File: tb/tb_swfield_ctrl.sv
`timescale 1ns/1ps
module tb_swfield_ctrl;
   import swfield_pkg::*;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst = 1'b1;
   logic req = 1'b0, req_wr = 1'b0, sel = 1'b0, qual_in = 1'b0;
   logic [7:0] wr_data = 8'h00;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // dut: plain write, read-clear, active-high qualifier, reset 0xF0
   logic [7:0] d_rd, d_q;
   logic d_acc, d_mod;
   swfield_ctrl #(.WIDTH(8), .RESET_VAL(8'hF0), .WR_MODE(WM_PLAIN),
                  .RD_MODE(RM_CLR), .QUAL_MODE(QM_HIGH)) dut (
      .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .sel(sel),
      .wr_data(wr_data), .qual_in(qual_in), .rd_data(d_rd), .field_q(d_q),
      .acc_strobe(d_acc), .mod_strobe(d_mod));

   // read-set, active-low qualifier, reset 0x0F
   logic [7:0] s_rd, s_q;
   logic s_acc, s_mod;
   swfield_ctrl #(.WIDTH(8), .RESET_VAL(8'h0F), .WR_MODE(WM_PLAIN),
                  .RD_MODE(RM_SET), .QUAL_MODE(QM_LOW)) u_rs (
      .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .sel(sel),
      .wr_data(wr_data), .qual_in(qual_in), .rd_data(s_rd), .field_q(s_q),
      .acc_strobe(s_acc), .mod_strobe(s_mod));

   // one instance per side-effect write mode, reset 0x00
   logic [7:0] w_rd [1:8];
   logic [7:0] w_q  [1:8];
   logic       w_acc [1:8];
   logic       w_mod [1:8];
   for (genvar k = 1; k <= 8; k++) begin : g_w
      swfield_ctrl #(.WIDTH(8), .RESET_VAL(8'h00), .WR_MODE(wr_mode_e'(k)),
                     .RD_MODE(RM_NONE), .QUAL_MODE(QM_NONE)) u_w (
         .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .sel(sel),
         .wr_data(wr_data), .qual_in(qual_in), .rd_data(w_rd[k]),
         .field_q(w_q[k]), .acc_strobe(w_acc[k]), .mod_strobe(w_mod[k]));
   end

   // reference state
   logic [7:0] m_d, m_s;
   logic [7:0] m_w [1:8];

   function automatic logic [7:0] wr_model(int m, logic [7:0] c, logic [7:0] d);
      case (m)
         1: return c | d;
         2: return c & ~d;
         3: return c ^ d;
         4: return c | ~d;
         5: return c & d;
         6: return c ^ ~d;
         7: return 8'h00;
         8: return 8'hFF;
         default: return d;
      endcase
   endfunction

   function automatic string mode_tag(int m);
      if (m <= 3) return "R2";
      if (m <= 6) return "R3";
      return "R4";
   endfunction

   task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cyc(logic r, logic w, logic s, logic q, logic [7:0] d);
      logic rd, wacc;
      @(negedge clk);
      req = r; req_wr = w; sel = s; qual_in = q; wr_data = d;
      #1;
      rd = r & s & ~w;
      wacc = r & s & w;
      // dut: R1/R5/R6 on value, R7/R8/R9 on strobes and read data
      chk("R1", "dut field", d_q, m_d);
      chk("R9", "dut rd_data", d_rd, rd ? m_d : 8'h00);
      chk("R7", "dut acc", {7'd0, d_acc}, {7'd0, rd});
      chk("R8", "dut mod", {7'd0, d_mod}, {7'd0, (wacc & q) | rd});
      chk("R5", "rs field", s_q, m_s);
      chk("R9", "rs rd_data", s_rd, rd ? m_s : 8'h00);
      chk("R6", "rs mod", {7'd0, s_mod}, {7'd0, (wacc & ~q) | rd});
      for (int k = 1; k <= 8; k++) begin
         chk(mode_tag(k), $sformatf("mode %0d field", k), w_q[k], m_w[k]);
         chk("R11", $sformatf("mode %0d mod", k), {7'd0, w_mod[k]}, {7'd0, wacc});
         chk("R7", $sformatf("mode %0d acc", k), {7'd0, w_acc[k]}, {7'd0, rd});
      end
      @(posedge clk);
      if (wacc && q) m_d = d; else if (rd) m_d = 8'h00;
      if (wacc && !q) m_s = d; else if (rd) m_s = 8'hFF;
      for (int k = 1; k <= 8; k++) if (wacc) m_w[k] = wr_model(k, m_w[k], d);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] lfsr;
      m_d = 8'hF0; m_s = 8'h0F;
      for (int k = 1; k <= 8; k++) m_w[k] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R10", "dut reset", d_q, 8'hF0);
      chk("R10", "rs reset", s_q, 8'h0F);
      for (int k = 1; k <= 8; k++) chk("R10", "mode reset", w_q[k], 8'h00);

      cyc(0, 0, 0, 0, 8'h00);          // idle
      cyc(1, 1, 1, 1, 8'hFE);          // R3 example: zero-set 00 -> 01; rs blocked
      cyc(1, 0, 1, 0, 8'h00);          // R5 read-clear / read-set
      cyc(1, 0, 1, 0, 8'h00);          // second read sees new value
      cyc(1, 1, 1, 0, 8'hA5);          // R6 dut blocked, rs loads
      cyc(1, 1, 1, 1, 8'hFF);
      cyc(1, 1, 0, 1, 8'h3C);          // R11 sel low ignored
      cyc(0, 1, 1, 1, 8'h3C);          // R11 req low ignored
      cyc(1, 1, 1, 1, 8'h00);
      cyc(1, 1, 1, 1, 8'hA5);
      cyc(1, 0, 1, 1, 8'h00);
      cyc(1, 1, 1, 0, 8'h0F);
      cyc(1, 1, 1, 1, 8'h5A);
      lfsr = 8'hB7;
      for (int i = 0; i < 60; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         cyc(lfsr[0] | lfsr[4], lfsr[1], lfsr[2] | lfsr[6], lfsr[3], lfsr ^ 8'h69);
      end
      cyc(0, 0, 0, 0, 8'h00);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule